// File: doc/BRIEF.md
# Quadrature chroma modulator with hue rotation

This block turns a stream of colour-difference sample pairs (blue difference and red difference) into one signed, modulated chroma sample per clock. Each component first passes through its own 8-bit gain stage, where code 0x80 stands for a gain of one. A 32-bit phase accumulator produces the colour subcarrier phase. Its top 8 bits address a sine/cosine table, and the scaled blue-difference sample is weighted by the sine while the scaled red-difference sample is weighted by the cosine. The two products are summed, rounded and saturated to a 10-bit signed result.

During the active picture an 8-bit hue code is added to the table address, which rotates the subcarrier by 360/256 degrees per unit. Outside the active picture the hue code plays no part and the chroma output is held at zero. A valid flag travels beside the data through a fixed two-stage pipeline, so the surrounding video path can line up the chroma with its luma.

Top module: `chroma_quad_mod`

## Requirements
- R1: Each component gain stage computes floor(sample * gain / 128) from a signed 8-bit sample and an unsigned 8-bit gain, saturated to the signed 8-bit range [-128, 127]. Gain 0x80 passes the sample unchanged.
- R2: The 32-bit phase accumulator is zero after reset and adds `phase_inc` (modulo 2^32) on every clock edge once reset has been released. A sample captured on an edge uses bits [31:24] of the accumulator value held just before that edge.
- R3: While `active` is 1 when a sample is captured, `hue` is added modulo 256 to the 8-bit table address. One hue unit rotates the subcarrier by 360/256 degrees.
- R4: A sample captured with `active` at 0 yields `chroma` = 0, whatever its components, gains and hue are.
- R5: For table address a, the sine code is round(127 * sin(2*pi*a/256)), with halves rounded away from zero. The cosine code is the sine code at address (a + 64) mod 256.
- R6: For an active sample with scaled components B and R, `chroma` = sat10((B*sin + R*cos + 32) >>> 6), where >>> is an arithmetic right shift and sat10 clamps to [-512, 511].
- R7: `out_valid` equals `in_valid` delayed by exactly two clocks. The result of a sample appears on `chroma` in that same cycle.
- R8: While `rst_n` is low, `out_valid` and `chroma` are 0. The internal reset is released on the second rising clock edge after `rst_n` goes high, and the accumulator starts to advance from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample pair is valid |
| active | input | 1 | Sample lies in the active picture |
| cb | input | 8 | Signed blue-difference sample |
| cr | input | 8 | Signed red-difference sample |
| gain_cb | input | 8 | Blue-difference gain, 0x80 = unity |
| gain_cr | input | 8 | Red-difference gain, 0x80 = unity |
| phase_inc | input | 32 | Subcarrier phase step per clock |
| hue | input | 8 | Hue rotation code, 360/256 degrees per unit |
| out_valid | output | 1 | Output sample is valid |
| chroma | output | 10 | Signed modulated chroma sample |

## Verification
Two functions can meet in the same cycle: the accumulator steps to a new phase, and the `active` flag switches the hue rotation and the zero forcing on or off. The bench provokes this by toggling `active` on every sample, with a non-zero hue, a non-zero phase step and gaps in `in_valid`. Each output is judged against a model that uses the accumulator value, hue state and active state seen at that sample's own capture edge. A result that took the rotation or the zero forcing from a neighbouring sample would therefore show up as a wrong chroma value two clocks later.

// File: rtl/chroma_mod_pkg.sv
package chroma_mod_pkg;

  // Default widths shared by the modulator and its sub-blocks
  localparam int unsigned DEF_SAMPLE_W = 8;
  localparam int unsigned DEF_GAIN_W   = 8;
  localparam int unsigned DEF_PHASE_W  = 32;
  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_TRIG_W   = 8;
  localparam int unsigned DEF_OUT_W    = 10;
  localparam int unsigned DEF_SHIFT    = 6;

  // Side-band flags carried alongside the data through the pipeline
  typedef struct packed {
    logic valid;
    logic active;
  } chroma_tag_t;

endpackage

// File: rtl/chroma_gain_stage.sv
module chroma_gain_stage #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned GAIN_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [GAIN_W-1:0]   gain,
  output logic signed [SAMPLE_W-1:0] scaled_q
);

  localparam int unsigned PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam int unsigned FRAC   = GAIN_W - 1;
  localparam logic signed [PROD_W-1:0] SAT_HI =
    $signed({{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}});
  localparam logic signed [PROD_W-1:0] SAT_LO =
    $signed({{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}});
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << FRAC);

  logic signed [PROD_W-1:0]   s_ext;
  logic signed [PROD_W-1:0]   g_ext;
  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   shifted;
  logic signed [SAMPLE_W-1:0] scaled_d;

  always_comb begin
    s_ext   = $signed({{(PROD_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample});
    g_ext   = $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
    prod    = s_ext * g_ext;
    shifted = prod >>> FRAC;
    if (shifted > SAT_HI) begin
      scaled_d = SAT_HI[SAMPLE_W-1:0];
    end else if (shifted < SAT_LO) begin
      scaled_d = SAT_LO[SAMPLE_W-1:0];
    end else begin
      scaled_d = shifted[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scaled_q <= '0;
    end else if (en) begin
      scaled_q <= scaled_d;
    end
  end

  // R1
  unity_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gain == UNITY) |=> scaled_q == $past(sample));

endmodule

// File: rtl/chroma_phase_gen.sv
module chroma_phase_gen #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               active,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [ADDR_W-1:0]  hue,
  output logic [ADDR_W-1:0]  addr_q
);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] acc_d;
  logic [ADDR_W-1:0]  hue_eff;
  logic [ADDR_W-1:0]  addr_d;

  always_comb begin
    acc_d   = acc_q + phase_inc;
    hue_eff = active ? hue : '0;
    addr_d  = acc_q[PHASE_W-1 -: ADDR_W] + hue_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
    end
  end

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_inc == '0) |=> $stable(acc_q));

  // R3
  hue_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !active) |=> addr_q == $past(acc_q[PHASE_W-1 -: ADDR_W]));

endmodule

// File: rtl/chroma_trig_lut.sv
module chroma_trig_lut #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TRIG_W = 8
) (
  input  logic        [ADDR_W-1:0] addr,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned QTR   = DEPTH / 4;
  localparam int          AMP   = (1 << (TRIG_W - 1)) - 1;

  function automatic int sine_code(input int k);
    real v;
    v = real'(AMP) * $sin(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH));
    if (v >= 0.0) begin
      return $rtoi(v + 0.5);
    end
    return -$rtoi(0.5 - v);
  endfunction

  logic signed [TRIG_W-1:0] tab [DEPTH];
  logic        [ADDR_W-1:0] cos_addr;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    assign tab[k] = TRIG_W'(sine_code(k));
  end

  always_comb begin
    cos_addr = addr + ADDR_W'(QTR);
    sin_o    = tab[addr];
    cos_o    = tab[cos_addr];
  end

endmodule

// File: rtl/chroma_quad_mod.sv
module chroma_quad_mod
  import chroma_mod_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
  parameter int unsigned GAIN_W    = DEF_GAIN_W,
  parameter int unsigned PHASE_W   = DEF_PHASE_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned TRIG_W    = DEF_TRIG_W,
  parameter int unsigned OUT_W     = DEF_OUT_W,
  parameter int unsigned OUT_SHIFT = DEF_SHIFT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       active,
  input  logic signed [SAMPLE_W-1:0] cb,
  input  logic signed [SAMPLE_W-1:0] cr,
  input  logic        [GAIN_W-1:0]   gain_cb,
  input  logic        [GAIN_W-1:0]   gain_cr,
  input  logic        [PHASE_W-1:0]  phase_inc,
  input  logic        [ADDR_W-1:0]   hue,
  output logic                       out_valid,
  output logic signed [OUT_W-1:0]    chroma
);

  localparam int unsigned N_COMP = 2;
  localparam int unsigned SUM_W  = SAMPLE_W + TRIG_W + 1;
  localparam logic signed [SUM_W-1:0] ROUND = SUM_W'(1 << (OUT_SHIFT - 1));
  localparam logic signed [SUM_W-1:0] O_MAX = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] O_MIN = SUM_W'(-(1 << (OUT_W - 1)));

  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  // Stage 1: component gains and subcarrier address
  logic signed [SAMPLE_W-1:0] comp_in [N_COMP];
  logic        [GAIN_W-1:0]   comp_g  [N_COMP];
  logic signed [SAMPLE_W-1:0] comp_sc [N_COMP];

  assign comp_in[0] = cb;
  assign comp_in[1] = cr;
  assign comp_g[0]  = gain_cb;
  assign comp_g[1]  = gain_cr;

  for (genvar c = 0; c < N_COMP; c++) begin : g_comp
    chroma_gain_stage #(
      .SAMPLE_W (SAMPLE_W),
      .GAIN_W   (GAIN_W)
    ) i_gain (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .en       (in_valid),
      .sample   (comp_in[c]),
      .gain     (comp_g[c]),
      .scaled_q (comp_sc[c])
    );
  end

  logic [ADDR_W-1:0] s1_addr;

  chroma_phase_gen #(
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W)
  ) i_phase (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (in_valid),
    .active    (active),
    .phase_inc (phase_inc),
    .hue       (hue),
    .addr_q    (s1_addr)
  );

  chroma_tag_t s1_tag_d;
  chroma_tag_t s1_tag_q;

  always_comb begin
    s1_tag_d.valid  = in_valid;
    s1_tag_d.active = in_valid ? active : s1_tag_q.active;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      s1_tag_q <= '0;
    end else begin
      s1_tag_q <= s1_tag_d;
    end
  end

  // Stage 2: lookup, quadrature products, rounding and gating
  logic signed [TRIG_W-1:0] sin_v;
  logic signed [TRIG_W-1:0] cos_v;

  chroma_trig_lut #(
    .ADDR_W (ADDR_W),
    .TRIG_W (TRIG_W)
  ) i_lut (
    .addr  (s1_addr),
    .sin_o (sin_v),
    .cos_o (cos_v)
  );

  logic signed [SUM_W-1:0] b_ext, r_ext, sn_ext, cs_ext;
  logic signed [SUM_W-1:0] sum_v, rnd_v, shr_v;
  logic signed [OUT_W-1:0] sat_v;
  logic signed [OUT_W-1:0] chroma_d;

  always_comb begin
    b_ext  = $signed({{(SUM_W-SAMPLE_W){comp_sc[0][SAMPLE_W-1]}}, comp_sc[0]});
    r_ext  = $signed({{(SUM_W-SAMPLE_W){comp_sc[1][SAMPLE_W-1]}}, comp_sc[1]});
    sn_ext = $signed({{(SUM_W-TRIG_W){sin_v[TRIG_W-1]}}, sin_v});
    cs_ext = $signed({{(SUM_W-TRIG_W){cos_v[TRIG_W-1]}}, cos_v});
    sum_v  = b_ext * sn_ext + r_ext * cs_ext;
    rnd_v  = sum_v + ROUND;
    shr_v  = rnd_v >>> OUT_SHIFT;
    if (shr_v > O_MAX) begin
      sat_v = O_MAX[OUT_W-1:0];
    end else if (shr_v < O_MIN) begin
      sat_v = O_MIN[OUT_W-1:0];
    end else begin
      sat_v = shr_v[OUT_W-1:0];
    end
    chroma_d = s1_tag_q.active ? sat_v : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s1_tag_q.valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      chroma <= '0;
    end else if (s1_tag_q.valid) begin
      chroma <= chroma_d;
    end
  end

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid == $past(in_valid, 2));

  // R4
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !$past(active, 2)) |-> chroma == '0);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && chroma == '0));

endmodule

// File: tb/test_chroma_quad_mod.sv
module test_chroma_quad_mod;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              active;
  logic signed [7:0] cb, cr;
  logic        [7:0] gain_cb, gain_cr, hue;
  logic       [31:0] phase_inc;
  logic              out_valid;
  logic signed [9:0] chroma;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  chroma_quad_mod i_chroma_quad_mod (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .active    (active),
    .cb        (cb),
    .cr        (cr),
    .gain_cb   (gain_cb),
    .gain_cr   (gain_cr),
    .phase_inc (phase_inc),
    .hue       (hue),
    .out_valid (out_valid),
    .chroma    (chroma)
  );

  // Phase model from R2 and R8: two-edge release, then one step per edge
  logic [1:0]  m_rel;
  logic [31:0] m_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel <= 2'b00;
      m_acc <= 32'd0;
    end else begin
      m_rel <= {m_rel[0], 1'b1};
      if (m_rel[1]) m_acc <= m_acc + phase_inc;
    end
  end

  function automatic int ref_sin(input int a);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic int ref_gain(input int s, input int g);
    int p;
    p = (s * g) >>> 7;
    if (p > 127) p = 127;
    if (p < -128) p = -128;
    return p;
  endfunction

  function automatic int ref_out(input bit a, input int b_in, input int r_in,
                                 input int gb, input int gr, input int h,
                                 input logic [31:0] acc);
    int addr, s, c, bs, rs, sum, r;
    if (!a) return 0;
    addr = (int'(acc[31:24]) + h) % 256;
    s    = ref_sin(addr);
    c    = ref_sin((addr + 64) % 256);
    bs   = ref_gain(b_in, gb);
    rs   = ref_gain(r_in, gr);
    sum  = bs * s + rs * c;
    r    = (sum + 32) >>> 6;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Two-deep expectation pipeline matching the R7 latency
  bit    d1_v, d2_v;
  int    d1_c, d2_c;
  string d1_r, d2_r;

  task automatic cyc(input bit v, input bit a, input int b_in, input int r_in,
                     input int gb, input int gr, input int h,
                     input logic [31:0] inc, input string req);
    @(negedge clk);
    chk("R7", int'(out_valid), int'(d2_v));
    if (d2_v) chk(d2_r, int'(chroma), d2_c);
    d2_v = d1_v; d2_c = d1_c; d2_r = d1_r;
    in_valid  = v;
    active    = a;
    cb        = 8'(b_in);
    cr        = 8'(r_in);
    gain_cb   = 8'(gb);
    gain_cr   = 8'(gr);
    hue       = 8'(h);
    phase_inc = inc;
    d1_v = v;
    d1_r = req;
    d1_c = ref_out(a, b_in, r_in, gb, gr, h, m_acc);
  endtask

  task automatic drain();
    cyc(1'b0, 1'b0, 0, 0, 128, 128, 0, 32'd0, "R7");
    cyc(1'b0, 1'b0, 0, 0, 128, 128, 0, 32'd0, "R7");
    cyc(1'b0, 1'b0, 0, 0, 128, 128, 0, 32'd0, "R7");
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; active = 1'b0; cb = '0; cr = '0;
    gain_cb = 8'h80; gain_cr = 8'h80; hue = '0; phase_inc = '0;
    d1_v = 1'b0; d2_v = 1'b0;
    repeat (3) @(negedge clk);
    // R8: quiet outputs during reset
    chk("R8", int'(out_valid), 0);
    chk("R8", int'(chroma), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", int'(out_valid), 0);
  endtask

  // R8: first sample after release sees phase 0 -> cos = 127, 100*127 -> 198
  task automatic t_after_reset();
    cyc(1'b1, 1'b1, 0, 100, 128, 128, 0, 32'h0100_0000, "R8");
    drain();
    chk("R8", ref_out(1'b1, 0, 100, 128, 128, 0, 32'd0), 198);
  endtask

  // R1 R2 R5 R6: unity gains, one address step per clock
  task automatic t_unity();
    for (int i = 0; i < 12; i++)
      cyc(1'b1, 1'b1, 20 * i - 110, 90 - 15 * i, 128, 128, 0, 32'h0100_0000, "R6");
    drain();
  endtask

  // R5: quarter-turn steps expose the sine/cosine signs per quadrant
  task automatic t_quadrants();
    for (int i = 0; i < 8; i++)
      cyc(1'b1, 1'b1, 100, 0, 128, 128, 0, 32'h4000_0000, "R5");
    for (int i = 0; i < 8; i++)
      cyc(1'b1, 1'b1, 0, -100, 128, 128, 0, 32'h2000_0000, "R5");
    drain();
  endtask

  // R1: attenuation, zero gain and saturation at both extremes
  task automatic t_gain();
    cyc(1'b1, 1'b1, 127, -128, 64, 64, 0, 32'h0700_0000, "R1");
    cyc(1'b1, 1'b1, 127, -128, 255, 255, 0, 32'h0700_0000, "R1");
    cyc(1'b1, 1'b1, -128, 127, 255, 0, 0, 32'h0700_0000, "R1");
    cyc(1'b1, 1'b1, -1, 1, 255, 255, 0, 32'h0700_0000, "R1");
    cyc(1'b1, 1'b1, -128, -128, 128, 128, 0, 32'h0700_0000, "R1");
    drain();
    chk("R1", ref_gain(127, 255), 127);
    chk("R1", ref_gain(-128, 255), -128);
  endtask

  // R3: frozen phase, hue rotates by quarter and eighth turns
  task automatic t_hue();
    for (int h = 0; h < 256; h += 32)
      cyc(1'b1, 1'b1, 80, 40, 128, 128, h, 32'd0, "R3");
    cyc(1'b1, 1'b1, 80, 40, 128, 128, 255, 32'd0, "R3");
    drain();
  endtask

  // R4: blanked samples give zero whatever the inputs
  task automatic t_blank();
    for (int i = 0; i < 6; i++)
      cyc(1'b1, 1'b0, 127 - 30 * i, -128 + 40 * i, 255, 200, 77, 32'h1234_5678, "R4");
    drain();
  endtask

  // R3 R4 R7: active toggles every sample, with valid gaps and a moving phase
  task automatic t_boundary();
    for (int i = 0; i < 24; i++)
      cyc((i % 5) != 3, (i % 2) == 0, 60 + i, -50 + 3 * i, 160, 100, 40,
          32'h0300_0000 + 32'(i), (i % 2) == 0 ? "R3" : "R4");
    drain();
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    t_reset();
    t_after_reset();
    t_unity();
    t_quadrants();
    t_gain();
    t_hue();
    t_blank();
    t_boundary();
    t_reset();
    t_after_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule